// File: doc/BRIEF.md
# Serial Command Port with Display Buffer Writer

This block is the host-facing command port of a dot-matrix display controller. A host talks to it as a serial slave (clock idle high, most significant bit first) while holding an active-low enable. The first byte of each enable period is a command, and every byte after it is data for that command. The port turns these bytes into writes into a 32-entry character buffer and into updates of the duty, digit-count, mode and cursor registers. At the same time it shifts bytes back to the host: either a key status byte or the key matrix rows.

SCLK, SIMO and the enable are brought into the system clock domain through a synchronizer and are edge-detected there. The SCLK half period must therefore span several system clocks. A write-address counter steps after each character byte. When a write lands on the last address, the counter wraps and later writes in the same transfer are suppressed. The key scanner gets one-cycle pulses so that it can clear its flag after a keyscan read or hold its data during a null read.

Top module: `disp_spi_ctrl`

## Requirements
- R1: SIMO is sampled on rising SCLK edges while en_ni is low. Each group of 8 bits forms a byte, most significant bit first, and SCLK idles high.
- R2: somi_o changes only after falling SCLK edges and sends each byte most significant bit first. somi_oe_o is high only while en_ni is low.
- R3: The first byte of an enable period is the command and every later byte is data. A byte that looks like a command in a data position is treated as data.
- R4: Command upper nibble 8h loads the write address from bits 4:0 of its first data byte. Its later data bytes are written as characters.
- R5: Command upper nibble 9h writes each data byte with a one-cycle buf_we_o pulse at the current write address, and the address then advances by one.
- R6: After a write to address 31 the address wraps to 0 and keeps advancing. No further buf_we_o pulse occurs until en_ni rises, and the next transfer writes again.
- R7: Command upper nibble Ah puts its bits 1:0 into duty_o[9:8] and its data byte into duty_o[7:0], updated when the data byte arrives.
- R8: Command nibble Bh sets digits_o from its bits 3:0. Nibble Ch sets mode_o from its bits 2:0. Mode 001 raises lamp_test_o, 010 raises low_power_o and 100 raises blank_o; every other code raises none.
- R9: Command nibble Dh takes four data bytes into cursor_o[7:0], [15:8], [23:16] and [31:24] in that order, and ignores any extra bytes.
- R10: For every command other than Eh and the byte 00h, each byte returned is the status byte: 00h when key_new_i is high and FFh when it is low.
- R11: For command Eh and the null byte 00h, the returned bytes run status, row 1 to row 5, then repeat from status. Row r is {2'b00, key_rows_i[6(r-1)+5 : 6(r-1)]}.
- R12: key_read_done_o pulses for one cycle when an Eh transfer ends. null_read_start_o pulses for one cycle when the 00h command byte is received.
- R13: Reset clears duty, digit count, mode, cursor, the write address and the serial logic, and issues no buf_we_o pulse.
- R14: If en_ni rises in the middle of a byte, the partial byte is discarded with no effect, and the next transfer is aligned to its own first bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sclk_i | input | 1 | Serial clock from host, idle high |
| simo_i | input | 1 | Serial data from host |
| en_ni | input | 1 | Transfer enable, active low |
| key_new_i | input | 1 | New key data available |
| key_rows_i | input | 30 | Key matrix rows, six column bits per row |
| somi_o | output | 1 | Serial data to host |
| somi_oe_o | output | 1 | Output enable for somi_o |
| buf_we_o | output | 1 | Character buffer write strobe |
| buf_addr_o | output | 5 | Character buffer write address |
| buf_data_o | output | 8 | Character code to write |
| duty_o | output | 10 | Display duty value |
| digits_o | output | 4 | Digit pair count (0 means 16) |
| mode_o | output | 3 | Raw mode code |
| lamp_test_o | output | 1 | Lamp test mode active |
| low_power_o | output | 1 | Low power mode active |
| blank_o | output | 1 | Blank mode active |
| cursor_o | output | 32 | Cursor mask, line 1 in 15:0, line 2 in 31:16 |
| key_read_done_o | output | 1 | Pulse at the end of a keyscan read transfer |
| null_read_start_o | output | 1 | Pulse when a null command is received |

## Verification
The hardest case to reach is write suppression after the wrap. It only appears when a single transfer carries character bytes past the last buffer location, and its end is visible only because the address counter keeps moving with writes disabled. The stimulus sets the address to 30 and sends four characters in one enable period. It then starts a fresh character transfer and expects the write to land at address 2. An enable rise in the middle of a byte is forced by stopping the clocking after a few bits, both in a command byte and in a data byte. The register that byte could have changed is then read at the ports.

// File: rtl/dsc_pkg.sv
package dsc_pkg;
  localparam int BYTE_W     = 8;
  localparam int DUTY_W     = 10;
  localparam int DUTY_HI_W  = DUTY_W - BYTE_W;
  localparam int DIGIT_W    = 4;
  localparam int MODE_W     = 3;
  localparam int CURSOR_W   = 32;
  localparam int LANES      = CURSOR_W / BYTE_W;

  localparam logic [3:0] NIB_ADDR   = 4'h8;
  localparam logic [3:0] NIB_CHAR   = 4'h9;
  localparam logic [3:0] NIB_DUTY   = 4'hA;
  localparam logic [3:0] NIB_DIGITS = 4'hB;
  localparam logic [3:0] NIB_MODE   = 4'hC;
  localparam logic [3:0] NIB_CURSOR = 4'hD;
  localparam logic [3:0] NIB_KEYRD  = 4'hE;

  localparam logic [MODE_W-1:0] MODE_LAMP   = 3'b001;
  localparam logic [MODE_W-1:0] MODE_LOWPWR = 3'b010;
  localparam logic [MODE_W-1:0] MODE_BLANK  = 3'b100;

  typedef enum logic [2:0] {
    OP_NONE, OP_ADDR, OP_CHAR, OP_DUTY, OP_CURSOR, OP_KEYRD, OP_NULL
  } op_e;

  function automatic op_e op_of(input logic [BYTE_W-1:0] b);
    op_e op;
    if (b == '0) op = OP_NULL;
    else begin
      case (b[7:4])
        NIB_ADDR:   op = OP_ADDR;
        NIB_CHAR:   op = OP_CHAR;
        NIB_DUTY:   op = OP_DUTY;
        NIB_CURSOR: op = OP_CURSOR;
        NIB_KEYRD:  op = OP_KEYRD;
        default:    op = OP_NONE;
      endcase
    end
    return op;
  endfunction
endpackage

// File: rtl/dsc_sync.sv
module dsc_sync #(
  parameter int               WIDTH   = 1,
  parameter int               STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [STAGES-1:0][WIDTH-1:0] stg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= RST_VAL;
    end else begin
      for (int i = STAGES - 1; i > 0; i--) stg_q[i] <= stg_q[i-1];
      stg_q[0] <= d_i;
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/dsc_serial.sv
module dsc_serial
  import dsc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sclk_i,
  input  logic              simo_i,
  input  logic              en_i,
  input  logic [BYTE_W-1:0] tx_byte_i,
  output logic              active_o,
  output logic              start_o,
  output logic              end_o,
  output logic              rx_valid_o,
  output logic [BYTE_W-1:0] rx_byte_o,
  output logic              tx_load_o,
  output logic              somi_o
);
  localparam int BIT_W = $clog2(BYTE_W);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(BYTE_W - 1);

  logic              sclk_q, en_q;
  logic              rise, fall;
  logic [BIT_W-1:0]  rcnt_q, fcnt_q;
  logic [BYTE_W-2:0] rsh_q;
  logic [BYTE_W-1:0] tsh_q;
  logic              rx_valid_q;
  logic [BYTE_W-1:0] rx_byte_q;

  assign active_o = ~en_i;
  assign start_o  = ~en_i & en_q;
  assign end_o    = en_i & ~en_q;
  assign rise     = active_o & sclk_i & ~sclk_q;
  assign fall     = active_o & ~sclk_i & sclk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_q <= 1'b1;
      en_q   <= 1'b1;
    end else begin
      sclk_q <= sclk_i;
      en_q   <= en_i;
    end
  end

  // receive: partial bytes die when enable goes inactive
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rcnt_q     <= '0;
      rsh_q      <= '0;
      rx_valid_q <= 1'b0;
      rx_byte_q  <= '0;
    end else begin
      rx_valid_q <= 1'b0;
      if (!active_o) begin
        rcnt_q <= '0;
      end else if (rise) begin
        rsh_q  <= {rsh_q[BYTE_W-3:0], simo_i};
        rcnt_q <= rcnt_q + 1'b1;
        if (rcnt_q == LAST_BIT) begin
          rx_valid_q <= 1'b1;
          rx_byte_q  <= {rsh_q, simo_i};
        end
      end
    end
  end

  // transmit: first falling edge of each byte loads a fresh byte
  assign tx_load_o = fall && (fcnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fcnt_q <= '0;
      tsh_q  <= '1;
    end else if (!active_o) begin
      fcnt_q <= '0;
    end else if (fall) begin
      fcnt_q <= fcnt_q + 1'b1;
      tsh_q  <= tx_load_o ? tx_byte_i : {tsh_q[BYTE_W-2:0], 1'b1};
    end
  end

  assign rx_valid_o = rx_valid_q;
  assign rx_byte_o  = rx_byte_q;
  assign somi_o     = tsh_q[BYTE_W-1];

  assert_byte_pulse_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o |=> !rx_valid_o);

  assert_somi_on_fall_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(active_o) && active_o && !$past(sclk_q && !sclk_i)) |-> $stable(somi_o));
endmodule

// File: rtl/dsc_readback.sv
module dsc_readback
  import dsc_pkg::*;
#(
  parameter int ROWS = 5,
  parameter int COLS = 6
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 start_i,
  input  logic                 tx_load_i,
  input  logic                 rd_mode_i,
  input  logic                 key_new_i,
  input  logic [ROWS*COLS-1:0] rows_i,
  output logic [BYTE_W-1:0]    tx_byte_o
);
  localparam int POS_W = $clog2(ROWS + 1);
  localparam logic [POS_W-1:0] LAST_POS = POS_W'(ROWS);

  logic [POS_W-1:0]             pos_q, ridx;
  logic [ROWS-1:0][BYTE_W-1:0]  row_bytes;
  logic [BYTE_W-1:0]            status;

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    assign row_bytes[r] = {{(BYTE_W-COLS){1'b0}}, rows_i[r*COLS +: COLS]};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        pos_q <= '0;
    else if (start_i)   pos_q <= '0;
    else if (tx_load_i) pos_q <= (pos_q == LAST_POS) ? '0 : pos_q + 1'b1;
  end

  assign status    = key_new_i ? '0 : '1;
  assign ridx      = pos_q - 1'b1;
  assign tx_byte_o = (rd_mode_i && pos_q != '0) ? row_bytes[ridx] : status;

  assert_pos_range_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pos_q <= LAST_POS);

  assert_pos_restart_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (pos_q == '0));
endmodule

// File: rtl/dsc_decode.sv
module dsc_decode
  import dsc_pkg::*;
#(
  parameter int DEPTH = 32,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                rx_valid_i,
  input  logic [BYTE_W-1:0]   rx_byte_i,
  input  logic                end_i,
  output logic                rd_mode_o,
  output logic                buf_we_o,
  output logic [ADDR_W-1:0]   buf_addr_o,
  output logic [BYTE_W-1:0]   buf_data_o,
  output logic [DUTY_W-1:0]   duty_o,
  output logic [DIGIT_W-1:0]  digits_o,
  output logic [MODE_W-1:0]   mode_o,
  output logic                lamp_test_o,
  output logic                low_power_o,
  output logic                blank_o,
  output logic [CURSOR_W-1:0] cursor_o,
  output logic                key_read_done_o,
  output logic                null_read_start_o
);
  localparam int DIDX_W = $clog2(LANES + 1);
  localparam logic [DIDX_W-1:0] DIDX_MAX  = DIDX_W'(LANES);
  localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(DEPTH - 1);

  logic                 first_q, wr_block_q;
  op_e                  op_q;
  logic [DIDX_W-1:0]    didx_q;
  logic [DUTY_HI_W-1:0] duty_hi_q;
  logic [ADDR_W-1:0]    wr_addr_q, buf_addr_q;
  logic [BYTE_W-1:0]    buf_data_q;
  logic                 buf_we_q, null_q, done_q;
  logic [DUTY_W-1:0]    duty_q;
  logic [DIGIT_W-1:0]   digits_q;
  logic [MODE_W-1:0]    mode_q;
  logic                 cmd_byte, data_byte, addr_load, char_wr;

  assign cmd_byte  = rx_valid_i && first_q;
  assign data_byte = rx_valid_i && !first_q;
  assign addr_load = data_byte && op_q == OP_ADDR && didx_q == '0;
  assign char_wr   = data_byte && (op_q == OP_CHAR || (op_q == OP_ADDR && didx_q != '0));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      first_q    <= 1'b1;
      op_q       <= OP_NONE;
      didx_q     <= '0;
      duty_hi_q  <= '0;
      wr_addr_q  <= '0;
      wr_block_q <= 1'b0;
      buf_we_q   <= 1'b0;
      buf_addr_q <= '0;
      buf_data_q <= '0;
      null_q     <= 1'b0;
      done_q     <= 1'b0;
    end else begin
      buf_we_q <= 1'b0;
      null_q   <= 1'b0;
      done_q   <= end_i && (op_q == OP_KEYRD);
      if (cmd_byte) begin
        first_q   <= 1'b0;
        op_q      <= op_of(rx_byte_i);
        duty_hi_q <= rx_byte_i[DUTY_HI_W-1:0];
        didx_q    <= '0;
        null_q    <= (rx_byte_i == '0);
      end
      if (data_byte && didx_q != DIDX_MAX) didx_q <= didx_q + 1'b1;
      if (addr_load) wr_addr_q <= rx_byte_i[ADDR_W-1:0];
      if (char_wr) begin
        buf_we_q   <= !wr_block_q;
        buf_addr_q <= wr_addr_q;
        buf_data_q <= rx_byte_i;
        wr_addr_q  <= wr_addr_q + 1'b1;
        // counter keeps moving after the wrap, writes stay off
        if (wr_addr_q == LAST_ADDR) wr_block_q <= 1'b1;
      end
      if (end_i) begin
        first_q    <= 1'b1;
        op_q       <= OP_NONE;
        didx_q     <= '0;
        wr_block_q <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      duty_q   <= '0;
      digits_q <= '0;
      mode_q   <= '0;
    end else begin
      if (cmd_byte && rx_byte_i[7:4] == NIB_DIGITS) digits_q <= rx_byte_i[DIGIT_W-1:0];
      if (cmd_byte && rx_byte_i[7:4] == NIB_MODE)   mode_q   <= rx_byte_i[MODE_W-1:0];
      if (data_byte && op_q == OP_DUTY && didx_q == '0) duty_q <= {duty_hi_q, rx_byte_i};
    end
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [BYTE_W-1:0] lane_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) lane_q <= '0;
      else if (data_byte && op_q == OP_CURSOR && didx_q == DIDX_W'(l)) lane_q <= rx_byte_i;
    end
    assign cursor_o[l*BYTE_W +: BYTE_W] = lane_q;
  end

  assign rd_mode_o         = (op_q == OP_KEYRD) || (op_q == OP_NULL);
  assign buf_we_o          = buf_we_q;
  assign buf_addr_o        = buf_addr_q;
  assign buf_data_o        = buf_data_q;
  assign duty_o            = duty_q;
  assign digits_o          = digits_q;
  assign mode_o            = mode_q;
  assign lamp_test_o       = (mode_q == MODE_LAMP);
  assign low_power_o       = (mode_q == MODE_LOWPWR);
  assign blank_o           = (mode_q == MODE_BLANK);
  assign key_read_done_o   = done_q;
  assign null_read_start_o = null_q;

  assert_wr_incr_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    buf_we_o |-> (wr_addr_q == ADDR_W'(buf_addr_o + 1'b1)));

  assert_no_write_blocked_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_block_q |=> !buf_we_o);

  assert_mode_onehot_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({lamp_test_o, low_power_o, blank_o}));

  assert_done_pulse_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    key_read_done_o |=> !key_read_done_o);

  assert_null_pulse_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    null_read_start_o |=> !null_read_start_o);
endmodule

// File: rtl/disp_spi_ctrl.sv
module disp_spi_ctrl
  import dsc_pkg::*;
#(
  parameter int DEPTH       = 32,
  parameter int ROWS        = 5,
  parameter int COLS        = 6,
  parameter int SYNC_STAGES = 2,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 sclk_i,
  input  logic                 simo_i,
  input  logic                 en_ni,
  input  logic                 key_new_i,
  input  logic [ROWS*COLS-1:0] key_rows_i,
  output logic                 somi_o,
  output logic                 somi_oe_o,
  output logic                 buf_we_o,
  output logic [ADDR_W-1:0]    buf_addr_o,
  output logic [BYTE_W-1:0]    buf_data_o,
  output logic [DUTY_W-1:0]    duty_o,
  output logic [DIGIT_W-1:0]   digits_o,
  output logic [MODE_W-1:0]    mode_o,
  output logic                 lamp_test_o,
  output logic                 low_power_o,
  output logic                 blank_o,
  output logic [CURSOR_W-1:0]  cursor_o,
  output logic                 key_read_done_o,
  output logic                 null_read_start_o
);
  logic              sclk_s, simo_s, en_s;
  logic              active, start, xfer_end, rx_valid, tx_load, rd_mode;
  logic [BYTE_W-1:0] rx_byte, tx_byte;

  dsc_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b110)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({en_ni, sclk_i, simo_i}),
    .q_o   ({en_s, sclk_s, simo_s})
  );

  dsc_serial u_serial (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sclk_i    (sclk_s),
    .simo_i    (simo_s),
    .en_i      (en_s),
    .tx_byte_i (tx_byte),
    .active_o  (active),
    .start_o   (start),
    .end_o     (xfer_end),
    .rx_valid_o(rx_valid),
    .rx_byte_o (rx_byte),
    .tx_load_o (tx_load),
    .somi_o    (somi_o)
  );

  dsc_readback #(.ROWS(ROWS), .COLS(COLS)) u_readback (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start),
    .tx_load_i(tx_load),
    .rd_mode_i(rd_mode),
    .key_new_i(key_new_i),
    .rows_i   (key_rows_i),
    .tx_byte_o(tx_byte)
  );

  dsc_decode #(.DEPTH(DEPTH)) u_decode (
    .clk_i            (clk_i),
    .rst_ni           (rst_ni),
    .rx_valid_i       (rx_valid),
    .rx_byte_i        (rx_byte),
    .end_i            (xfer_end),
    .rd_mode_o        (rd_mode),
    .buf_we_o         (buf_we_o),
    .buf_addr_o       (buf_addr_o),
    .buf_data_o       (buf_data_o),
    .duty_o           (duty_o),
    .digits_o         (digits_o),
    .mode_o           (mode_o),
    .lamp_test_o      (lamp_test_o),
    .low_power_o      (low_power_o),
    .blank_o          (blank_o),
    .cursor_o         (cursor_o),
    .key_read_done_o  (key_read_done_o),
    .null_read_start_o(null_read_start_o)
  );

  assign somi_oe_o = active;
endmodule

// File: tb/disp_spi_ctrl_bench.sv
module disp_spi_ctrl_bench;
  localparam int HALF = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sclk = 1'b1, simo = 1'b0, en_n = 1'b1;
  logic        key_new = 1'b0;
  logic [29:0] key_rows = '0;
  logic        somi, somi_oe, buf_we, lamp, lowp, blank, kdone, nstart;
  logic [4:0]  buf_addr;
  logic [7:0]  buf_data;
  logic [9:0]  duty;
  logic [3:0]  digits;
  logic [2:0]  mode;
  logic [31:0] cursor;

  int checks = 0, errors = 0;
  int done_cnt = 0, null_cnt = 0;
  logic [12:0] exp_wr[$];
  logic [7:0]  txb[16];
  logic [7:0]  rxb[16];

  always #5 clk = ~clk;

  disp_spi_ctrl u_disp_spi_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .sclk_i(sclk), .simo_i(simo), .en_ni(en_n),
    .key_new_i(key_new), .key_rows_i(key_rows), .somi_o(somi), .somi_oe_o(somi_oe),
    .buf_we_o(buf_we), .buf_addr_o(buf_addr), .buf_data_o(buf_data), .duty_o(duty),
    .digits_o(digits), .mode_o(mode), .lamp_test_o(lamp), .low_power_o(lowp),
    .blank_o(blank), .cursor_o(cursor), .key_read_done_o(kdone),
    .null_read_start_o(nstart)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic expect_wr(input logic [4:0] a, input logic [7:0] d);
    exp_wr.push_back({a, d});
  endtask

  // monitor: pulse counters and write scoreboard
  always @(negedge clk) begin
    if (kdone)  done_cnt++;
    if (nstart) null_cnt++;
    if (buf_we) begin
      checks++;
      if (exp_wr.size() == 0) begin
        errors++;
        $display("FAIL R6 actual=write %h@%0d expected=no write", buf_data, buf_addr);
      end else begin
        logic [12:0] e;
        e = exp_wr.pop_front();
        if ({buf_addr, buf_data} !== e) begin
          errors++;
          $display("FAIL R5 actual=%h@%0d expected=%h@%0d", buf_data, buf_addr, e[7:0], e[12:8]);
        end
      end
    end
  end

  task automatic xfer(input int n);
    tick(1); en_n = 1'b0; tick(HALF);
    for (int i = 0; i < n; i++) begin
      for (int b = 7; b >= 0; b--) begin
        sclk = 1'b0; simo = txb[i][b]; tick(HALF);
        rxb[i][b] = somi;
        sclk = 1'b1; tick(HALF);
      end
    end
    en_n = 1'b1; tick(2 * HALF);
  endtask

  task automatic partial(input logic [7:0] lead, input logic [7:0] b, input int with_lead, input int nbits);
    tick(1); en_n = 1'b0; tick(HALF);
    if (with_lead != 0) begin
      for (int k = 7; k >= 0; k--) begin
        sclk = 1'b0; simo = lead[k]; tick(HALF); sclk = 1'b1; tick(HALF);
      end
    end
    for (int k = 7; k > 7 - nbits; k--) begin
      sclk = 1'b0; simo = b[k]; tick(HALF); sclk = 1'b1; tick(HALF);
    end
    en_n = 1'b1; tick(2 * HALF);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    tick(4); rst_n = 1'b1; tick(4);
    // R13 reset state
    chk("R13 duty", 32'(duty), 0);
    chk("R13 digits", 32'(digits), 0);
    chk("R13 mode", 32'(mode), 0);
    chk("R13 cursor", cursor, 0);
    chk("R13 oe", 32'(somi_oe), 0);

    // R2 output enable follows enable
    en_n = 1'b0; tick(6);
    chk("R2 oe active", 32'(somi_oe), 1);
    en_n = 1'b1; tick(6);
    chk("R2 oe idle", 32'(somi_oe), 0);

    // R1 R7 R10 duty, no new keys
    txb[0] = 8'hA3; txb[1] = 8'h5C; xfer(2);
    chk("R1/R7 duty", 32'(duty), 32'h35C);
    chk("R10 status FF b0", 32'(rxb[0]), 32'hFF);
    chk("R10 status FF b1", 32'(rxb[1]), 32'hFF);

    // R8 R10 digits with new keys pending
    key_new = 1'b1;
    txb[0] = 8'hB5; txb[1] = 8'h77; xfer(2);
    chk("R8 digits", 32'(digits), 5);
    chk("R10 status 00 b0", 32'(rxb[0]), 0);
    chk("R10 status 00 b1", 32'(rxb[1]), 0);
    key_new = 1'b0;

    // R8 mode codes
    txb[0] = 8'hC1; xfer(1);
    chk("R8 lamp", {29'd0, lamp, lowp, blank}, 32'b100);
    txb[0] = 8'hC2; xfer(1);
    chk("R8 lowpower", {29'd0, lamp, lowp, blank}, 32'b010);
    txb[0] = 8'hC4; xfer(1);
    chk("R8 blank", {29'd0, lamp, lowp, blank}, 32'b001);
    txb[0] = 8'hCF; xfer(1);
    chk("R8 normal 111", {29'd0, lamp, lowp, blank}, 0);
    chk("R8 mode raw", 32'(mode), 7);

    // R9 cursor lanes, fifth data byte ignored
    txb[0] = 8'hD0; txb[1] = 8'h11; txb[2] = 8'h22; txb[3] = 8'h33;
    txb[4] = 8'h44; txb[5] = 8'h55; xfer(6);
    chk("R9 cursor", cursor, 32'h44332211);

    // R4 address set followed by characters
    expect_wr(5'd3, 8'h41); expect_wr(5'd4, 8'h42);
    txb[0] = 8'h80; txb[1] = 8'h03; txb[2] = 8'h41; txb[3] = 8'h42; xfer(4);
    chk("R4 writes done", 32'(exp_wr.size()), 0);

    // R3 R5 command-like data byte is a character
    expect_wr(5'd5, 8'h85); expect_wr(5'd6, 8'hB7);
    txb[0] = 8'h90; txb[1] = 8'h85; txb[2] = 8'hB7; xfer(3);
    chk("R3 digits unchanged", 32'(digits), 5);
    chk("R5 writes done", 32'(exp_wr.size()), 0);

    // R6 wrap and suppression, next transfer resumes at 2
    expect_wr(5'd30, 8'hA1); expect_wr(5'd31, 8'hA2);
    txb[0] = 8'h80; txb[1] = 8'h1E; txb[2] = 8'hA1; txb[3] = 8'hA2;
    txb[4] = 8'hA3; txb[5] = 8'hA4; xfer(6);
    chk("R6 blocked", 32'(exp_wr.size()), 0);
    expect_wr(5'd2, 8'h55);
    txb[0] = 8'h90; txb[1] = 8'h55; xfer(2);
    chk("R6 resumed", 32'(exp_wr.size()), 0);

    // R11 R12 keyscan read with wrap
    key_new = 1'b1;
    key_rows = {6'h2D, 6'h00, 6'h3F, 6'h12, 6'h21};
    txb[0] = 8'hE0;
    for (int i = 1; i < 8; i++) txb[i] = 8'hFF;
    xfer(8);
    chk("R11 status", 32'(rxb[0]), 0);
    chk("R11 row1", 32'(rxb[1]), 32'h21);
    chk("R11 row2", 32'(rxb[2]), 32'h12);
    chk("R11 row3", 32'(rxb[3]), 32'h3F);
    chk("R11 row4", 32'(rxb[4]), 32'h00);
    chk("R11 row5", 32'(rxb[5]), 32'h2D);
    chk("R11 wrap status", 32'(rxb[6]), 0);
    chk("R11 wrap row1", 32'(rxb[7]), 32'h21);
    chk("R12 done pulse", 32'(done_cnt), 1);
    chk("R12 no null", 32'(null_cnt), 0);

    // R11 R12 null read, no new keys
    key_new = 1'b0;
    txb[0] = 8'h00; txb[1] = 8'h00; txb[2] = 8'h00; xfer(3);
    chk("R11 null status", 32'(rxb[0]), 32'hFF);
    chk("R11 null row1", 32'(rxb[1]), 32'h21);
    chk("R11 null row2", 32'(rxb[2]), 32'h12);
    chk("R12 null pulse", 32'(null_cnt), 1);
    chk("R12 done unchanged", 32'(done_cnt), 1);

    // R14 aborted command byte and aborted data byte
    partial(8'h00, 8'hB9, 0, 5);
    chk("R14 digits kept", 32'(digits), 5);
    partial(8'hA1, 8'hFF, 1, 3);
    chk("R14 duty kept", 32'(duty), 32'h35C);
    txb[0] = 8'hB3; xfer(1);
    chk("R14 realigned", 32'(digits), 3);

    // R13 second reset, address back to 0, no stray write
    tick(1); rst_n = 1'b0; tick(4); rst_n = 1'b1; tick(4);
    chk("R13 duty again", 32'(duty), 0);
    chk("R13 cursor again", cursor, 0);
    expect_wr(5'd0, 8'h66);
    txb[0] = 8'h90; txb[1] = 8'h66; xfer(2);
    chk("R13 address zero", 32'(exp_wr.size()), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule